// File: doc/BRIEF.md
# Privilege and Banked Stack Selection Controller

This block holds the execution state of a small microcontroller-class core: whether the core runs ordinary thread code or services an exception in handler mode, and whether thread code runs with full or restricted privilege. It also keeps two banked stack-pointer registers, a main one and a process one. It selects the active register from the current state. A read port always returns the active register, and a write lands only in that register.

The surrounding core sends the block one-cycle strobes for exception entry and exception return, writes to the control bit that lowers privilege, writes to a one-bit exception-mask flag, and stack-pointer writes. All state changes take effect at the clock edge that samples the strobe. The outputs are registered state, or plain decodes of registered state. Privilege that thread code has given up comes back only through an exception. Decode, prioritisation, vectoring and context stacking stay in other blocks.

Top module: `priv_stack_ctrl`

## Requirements
- R1: After reset the block reports thread mode (`mode_handler`=0), privileged (`privileged`=1), main stack selected (`sp_sel_process`=0), `exc_mask`=0, `ctrl_fault`=0, and both banked stack pointers read as zero.
- R2: An `exc_enter` strobe puts the block in handler mode (`mode_handler`=1) at the next cycle, whatever its current mode. It also takes precedence over a simultaneous `exc_return`.
- R3: While `mode_handler`=1, `privileged` is 1, whatever privilege the interrupted thread had.
- R4: In privileged thread mode, `ctrl_wr` with `ctrl_wdata`=1 makes thread mode unprivileged from the next cycle. `ctrl_wdata`=0 leaves it privileged.
- R5: In unprivileged thread mode, `ctrl_wr` does not change privilege, and `ctrl_fault` is 1 for exactly the next cycle. `ctrl_wr` in handler mode has no effect and raises no fault.
- R6: `exc_return` in handler mode returns to thread mode at the next cycle, unprivileged if `ret_unpriv`=1 and privileged if 0. `exc_return` in thread mode is ignored.
- R7: `sp_sel_process` is 1 exactly when the block is in unprivileged thread mode. Otherwise the main stack pointer is active, and `sp_rdata` always shows the active register.
- R8: `sp_wr` writes `sp_wdata` with bits [1:0] cleared into the register that is active in that cycle only. The other bank keeps its value.
- R9: `mask_wr` loads `mask_wdata` into `exc_mask` only when `privileged`=1 in that cycle. Otherwise the mask is unchanged.
- R10: When `exc_enter` and `ctrl_wr` arrive in the same cycle, the control write is discarded and no fault is raised.
- R11: `privileged` rises from 0 to 1 only in the cycle after an `exc_enter` strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_enter | input | 1 | Exception entry strobe |
| exc_return | input | 1 | Exception return strobe |
| ret_unpriv | input | 1 | Return target privilege: 1 selects unprivileged thread |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 1 | Control value: 1 requests unprivileged thread |
| mask_wr | input | 1 | Exception-mask write strobe |
| mask_wdata | input | 1 | Exception-mask write value |
| sp_wr | input | 1 | Active stack-pointer write strobe |
| sp_wdata | input | SP_W | Stack-pointer write value |
| mode_handler | output | 1 | 1 in handler mode, 0 in thread mode |
| privileged | output | 1 | Current privilege |
| sp_sel_process | output | 1 | 1 when the process stack pointer is active |
| sp_rdata | output | SP_W | Active stack-pointer value |
| exc_mask | output | 1 | Masks exceptions of configurable priority |
| ctrl_fault | output | 1 | One-cycle flag for a refused control write |

## Verification
The assertions assume that every strobe and data input has a known value at each rising edge once reset is released. They also assume that a strobe given outside its useful state (a return in thread mode, for example) is legal input with a defined outcome. The bench holds all inputs at zero during reset and drives them on the falling edge only. Its random stimulus draws every strobe independently, so entry, return, control, mask and stack writes collide in the same cycle in every combination. No input is left undriven, and the stimulus never depends on the outputs.

// File: rtl/priv_pkg.sv
package priv_pkg;

  typedef enum logic {
    MODE_THREAD  = 1'b0,
    MODE_HANDLER = 1'b1
  } mode_e;

  localparam int unsigned NUM_SP_BANKS = 2;
  localparam int unsigned BANK_MAIN    = 0;
  localparam int unsigned BANK_PROCESS = 1;

  // privilege as seen from mode and the thread control bit
  function automatic logic priv_of(input mode_e m, input logic thread_unpriv);
    return (m == MODE_HANDLER) || !thread_unpriv;
  endfunction

endpackage

// File: rtl/mode_fsm.sv
module mode_fsm
  import priv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic exc_enter,
  input  logic exc_return,
  input  logic ret_unpriv,
  input  logic ctrl_wr,
  input  logic ctrl_wdata,
  output logic mode_handler,
  output logic privileged,
  output logic ctrl_fault
);

  mode_e mode_q;
  logic  thread_unpriv_q;
  logic  fault_q;

  // named events
  logic in_thread;
  logic ev_enter;
  logic ev_return;
  logic ev_ctrl_ok;
  logic ev_ctrl_bad;

  assign in_thread   = (mode_q == MODE_THREAD);
  assign privileged  = priv_of(mode_q, thread_unpriv_q);
  assign ev_enter    = exc_enter;
  assign ev_return   = exc_return && !in_thread && !exc_enter;
  assign ev_ctrl_ok  = ctrl_wr && !exc_enter && in_thread && !thread_unpriv_q;
  assign ev_ctrl_bad = ctrl_wr && !exc_enter && in_thread && thread_unpriv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q          <= MODE_THREAD;
      thread_unpriv_q <= 1'b0;
      fault_q         <= 1'b0;
    end else begin
      fault_q <= ev_ctrl_bad;
      if (ev_enter) begin
        mode_q <= MODE_HANDLER;
      end else if (ev_return) begin
        mode_q          <= MODE_THREAD;
        thread_unpriv_q <= ret_unpriv;
      end else if (ev_ctrl_ok) begin
        thread_unpriv_q <= ctrl_wdata;
      end
    end
  end

  assign mode_handler = (mode_q == MODE_HANDLER);
  assign ctrl_fault   = fault_q;

  p_enter_handler_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_enter |=> (mode_handler && privileged));

  p_drop_priv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_wdata && !exc_enter && !mode_handler && privileged) |=> !privileged);

  p_refused_ctrl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !exc_enter && !mode_handler && !privileged) |=> (ctrl_fault && !privileged));

  p_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && mode_handler && !exc_enter) |=>
      (!mode_handler && (privileged == !$past(ret_unpriv))));

  p_enter_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_enter && ctrl_wr) |=> !ctrl_fault);

  p_regain_priv_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(privileged) |-> $past(exc_enter));

endmodule

// File: rtl/mask_reg.sv
module mask_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic priv_now,
  input  logic wr,
  input  logic wdata,
  output logic mask
);

  logic mask_q;
  logic wr_accept;

  assign wr_accept = wr && priv_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= 1'b0;
    else if (wr_accept) mask_q <= wdata;
  end

  assign mask = mask_q;

  p_mask_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !priv_now) |=> $stable(mask_q));

  p_mask_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && priv_now) |=> (mask_q == $past(wdata)));

endmodule

// File: rtl/sp_bank.sv
module sp_bank
  import priv_pkg::*;
#(
  parameter int unsigned SP_W  = 32,
  parameter int unsigned ALIGN = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_process,
  input  logic            wr,
  input  logic [SP_W-1:0] wdata,
  output logic [SP_W-1:0] rdata
);

  localparam logic [SP_W-1:0] ALIGN_MASK = ~((SP_W'(1) << ALIGN) - SP_W'(1));

  function automatic logic [SP_W-1:0] align_sp(input logic [SP_W-1:0] v);
    return v & ALIGN_MASK;
  endfunction

  logic [SP_W-1:0] bank_q [NUM_SP_BANKS];
  logic [NUM_SP_BANKS-1:0] bank_we;

  assign bank_we[BANK_MAIN]    = wr && !sel_process;
  assign bank_we[BANK_PROCESS] = wr && sel_process;

  for (genvar b = 0; b < NUM_SP_BANKS; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_q[b] <= '0;
      else if (bank_we[b]) bank_q[b] <= align_sp(wdata);
    end

    p_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_q[b] & ~ALIGN_MASK) == '0);
  end

  assign rdata = sel_process ? bank_q[BANK_PROCESS] : bank_q[BANK_MAIN];

  p_one_bank_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_we));

  p_main_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && sel_process) |=> $stable(bank_q[BANK_MAIN]));

  p_proc_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !sel_process) |=> $stable(bank_q[BANK_PROCESS]));

endmodule

// File: rtl/priv_stack_ctrl.sv
module priv_stack_ctrl
  import priv_pkg::*;
#(
  parameter int unsigned SP_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_enter,
  input  logic            exc_return,
  input  logic            ret_unpriv,
  input  logic            ctrl_wr,
  input  logic            ctrl_wdata,
  input  logic            mask_wr,
  input  logic            mask_wdata,
  input  logic            sp_wr,
  input  logic [SP_W-1:0] sp_wdata,
  output logic            mode_handler,
  output logic            privileged,
  output logic            sp_sel_process,
  output logic [SP_W-1:0] sp_rdata,
  output logic            exc_mask,
  output logic            ctrl_fault
);

  logic use_process;

  mode_fsm u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .exc_enter    (exc_enter),
    .exc_return   (exc_return),
    .ret_unpriv   (ret_unpriv),
    .ctrl_wr      (ctrl_wr),
    .ctrl_wdata   (ctrl_wdata),
    .mode_handler (mode_handler),
    .privileged   (privileged),
    .ctrl_fault   (ctrl_fault)
  );

  assign use_process    = !privileged;
  assign sp_sel_process = use_process;

  mask_reg u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .priv_now (privileged),
    .wr       (mask_wr),
    .wdata    (mask_wdata),
    .mask     (exc_mask)
  );

  sp_bank #(.SP_W(SP_W), .ALIGN(2)) u_sp (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_process (use_process),
    .wr          (sp_wr),
    .wdata       (sp_wdata),
    .rdata       (sp_rdata)
  );

  p_handler_main_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_handler |-> (privileged && !sp_sel_process));

  p_process_thread_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sp_sel_process |-> !mode_handler);

endmodule

// File: tb/priv_stack_ctrl_tb.sv
module priv_stack_ctrl_tb;

  localparam int SP_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exc_enter = 0, exc_return = 0, ret_unpriv = 0, ctrl_wr = 0, ctrl_wdata = 0;
  logic mask_wr = 0, mask_wdata = 0, sp_wr = 0;
  logic [SP_W-1:0] sp_wdata = '0;
  logic mode_handler, privileged, sp_sel_process, exc_mask, ctrl_fault;
  logic [SP_W-1:0] sp_rdata;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  priv_stack_ctrl #(.SP_W(SP_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .exc_enter(exc_enter), .exc_return(exc_return),
    .ret_unpriv(ret_unpriv), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .sp_wr(sp_wr), .sp_wdata(sp_wdata),
    .mode_handler(mode_handler), .privileged(privileged), .sp_sel_process(sp_sel_process),
    .sp_rdata(sp_rdata), .exc_mask(exc_mask), .ctrl_fault(ctrl_fault)
  );

  typedef struct {
    logic h;
    logic tu;
    logic mask;
    logic fault;
    logic [SP_W-1:0] msp;
    logic [SP_W-1:0] psp;
  } st_t;

  st_t exp_s;

  function automatic logic m_priv(st_t s);
    return s.h ? 1'b1 : !s.tu;
  endfunction

  function automatic logic [SP_W-1:0] m_align(logic [SP_W-1:0] v);
    logic [SP_W-1:0] r = v;
    r[1:0] = 2'b00;
    return r;
  endfunction

  function automatic st_t m_next(st_t s, logic en, logic ret, logic ru, logic cw,
                                 logic cd, logic mw, logic md, logic sw,
                                 logic [SP_W-1:0] sd);
    st_t n = s;
    n.fault = 1'b0;
    if (sw) begin
      if (!m_priv(s)) n.psp = m_align(sd);
      else            n.msp = m_align(sd);
    end
    if (mw && m_priv(s)) n.mask = md;
    if (en) n.h = 1'b1;
    else if (ret && s.h) begin
      n.h  = 1'b0;
      n.tu = ru;
    end else if (cw && !s.h) begin
      if (m_priv(s)) n.tu = cd;
      else           n.fault = 1'b1;
    end
    return n;
  endfunction

  task automatic chk(string tag, logic [SP_W-1:0] act, logic [SP_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 R6 mode", {31'd0, mode_handler}, {31'd0, exp_s.h});
    chk("R3 R4 R11 privilege", {31'd0, privileged}, {31'd0, m_priv(exp_s)});
    chk("R7 stack select", {31'd0, sp_sel_process}, {31'd0, !m_priv(exp_s)});
    chk("R7 R8 stack value", sp_rdata, m_priv(exp_s) ? exp_s.msp : exp_s.psp);
    chk("R9 mask", {31'd0, exc_mask}, {31'd0, exp_s.mask});
    chk("R5 R10 fault", {31'd0, ctrl_fault}, {31'd0, exp_s.fault});
  endtask

  // called at a falling edge: checks, drives, advances one cycle
  task automatic step(logic en, logic ret, logic ru, logic cw, logic cd,
                      logic mw, logic md, logic sw, logic [SP_W-1:0] sd);
    check_all();
    exc_enter = en; exc_return = ret; ret_unpriv = ru; ctrl_wr = cw; ctrl_wdata = cd;
    mask_wr = mw; mask_wdata = md; sp_wr = sw; sp_wdata = sd;
    exp_s = m_next(exp_s, en, ret, ru, cw, cd, mw, md, sw, sd);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd20240522));
    exp_s = '{h: 1'b0, tu: 1'b0, mask: 1'b0, fault: 1'b0, msp: '0, psp: '0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset mode", {31'd0, mode_handler}, 32'd0);
    chk("R1 reset privilege", {31'd0, privileged}, 32'd1);
    chk("R1 reset stack", sp_rdata, 32'd0);
    chk("R1 reset mask", {31'd0, exc_mask}, 32'd0);

    // directed corners
    step(0,0,0, 1,0, 0,0, 1,32'h2000_0FFF); // R4 keep priv, R8 main write aligned
    step(0,0,0, 0,0, 1,1, 0,'0);            // R9 privileged mask write
    step(0,0,0, 1,1, 0,0, 0,'0);            // R4 drop privilege
    step(0,0,0, 0,0, 0,0, 1,32'h1000_0103); // R8 process write
    step(0,0,0, 1,0, 0,0, 0,'0);            // R5 refused control write
    step(0,0,0, 0,0, 1,0, 0,'0);            // R9 unprivileged mask write ignored
    step(0,1,0, 0,0, 0,0, 0,'0);            // R6 return in thread ignored
    step(1,0,0, 1,1, 0,0, 0,'0);            // R10 entry beats control write
    step(0,0,0, 1,1, 0,0, 0,'0);            // R5 handler control write no effect
    step(0,1,1, 0,0, 0,0, 0,'0);            // R6 return unprivileged
    step(1,1,0, 0,0, 0,0, 0,'0);            // R2 entry beats return
    step(0,1,0, 0,0, 0,0, 0,'0);            // R6 return privileged
    step(0,0,0, 0,0, 0,0, 0,'0);
    chk("R8 main bank kept", sp_rdata, 32'h2000_0FFC);

    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 10) == 0, ($urandom % 7) == 0, $urandom % 2,
           ($urandom % 5) == 0, $urandom % 2, ($urandom % 6) == 0, $urandom % 2,
           ($urandom % 3) == 0, $urandom);
    end
    check_all();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule